// File: doc/BRIEF.md
# Ten-Channel Phase-Locked PWM Generator

This block drives ten pulse-width modulated outputs from one shared 8-bit phase counter. A free-running prescaler produces a tick once every 2^PRESC_W system clocks (256 by default), and every tick advances the phase counter by one. A full output period is therefore 256 ticks, or 65536 clocks at the default setting. Each channel has an 8-bit duty value, giving a duty step of 1/256 of the period.

Software writes duties through a simple one-word-per-clock port into a shadow bank. The shadow bank is copied into the active bank only when the phase counter wraps from 255 to 0, so every period uses one consistent set of duties. Output pin states are worked out one tick ahead into a staging register. At each tick boundary, all ten pins are loaded from that staging register at once. Edge placement is therefore fixed to the tick grid and does not depend on which compares matched. A one-clock strobe marks every wrap, so duty updates can be aligned to period boundaries.

Top module: `pwm_multi`

## Requirements
- R1: Ten outputs share one phase counter, and each output has its own 8-bit duty value. Bit n of `pwm_o` belongs to channel n.
- R2: A tick occurs once every 2^PRESC_W clocks. The phase counter advances by exactly one per tick and holds between ticks, so one period is 256 ticks.
- R3: When `wr_en_i` is high, the clock writes `wr_duty_i` into the shadow duty of channel `wr_ch_i`. A write with `wr_ch_i` of 10 to 15 changes no channel.
- R4: Shadow duties are copied into the active bank only on the tick where the phase wraps from 255 to 0. A write made during a period does not change that period's waveform.
- R5: A channel with active duty 0 stays low for the whole period.
- R6: A channel with active duty d is high for exactly d ticks (4·d clocks when PRESC_W=2) in each period. The largest duty, 255, gives 255 ticks high, so no output is ever high for a whole period.
- R7: Outputs change only at tick boundaries. They carry a fixed one-tick latency: a channel rises one tick after the wrap edge and falls d ticks after that.
- R8: An active-low asynchronous reset clears the prescaler, phase, shadow bank, active bank, staging register and outputs. All outputs then stay low until a nonzero duty is written and a wrap occurs.
- R9: `wrap_o` is high for exactly one clock per period, in the clock that ends with the wrap edge. Consecutive pulses are 2^(PRESC_W+8) clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow duty write strobe |
| wr_ch_i | input | 4 | Channel index for the write |
| wr_duty_i | input | 8 | Duty value to write |
| pwm_o | output | 10 | PWM outputs, bit n is channel n |
| wrap_o | output | 1 | One-clock pulse at each phase wrap |

## Verification
The duty logic is exercised three ways: with ten distinct duties loaded at once, including 1, 2, 254 and 255; with the extremes 0 and 255 on neighbouring channels; and with a single small duty whose rising and falling clocks are timed against the wrap strobe. The distinct-duty set separates channels that share or swap compare slots. Counting high clocks over a full period checks off-by-one errors at both ends of the period. The edge timing shows whether pins follow the staged value or the live compare.

A duty write made early in a running period separates true double buffering from an early copy. Writes to indices 10 to 15 would show any aliasing onto real channels. A reset applied in the middle of a run confirms that the shadow bank is cleared as well as the outputs.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  localparam int unsigned DefNumCh  = 10;
  localparam int unsigned DefDutyW  = 8;
  localparam int unsigned DefIdxW   = 4;
  localparam int unsigned DefPrescW = 8;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               tick_o,
  output logic               wrap_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [PHASE_W-1:0] phase_q;

  assign tick_o  = &presc_q;
  assign wrap_o  = tick_o && (&phase_q);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      phase_q <= '0;
    end else begin
      presc_q <= presc_q + PRESC_W'(1);
      if (tick_o) phase_q <= phase_q + PHASE_W'(1);
    end
  end

  a_r2_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(phase_q));
  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> phase_q == $past(phase_q) + PHASE_W'(1));
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_ch_i,
  input  logic [DUTY_W-1:0]        wr_duty_i,
  input  logic                     load_i,
  output logic [NUM_CH*DUTY_W-1:0] shadow_o,
  output logic [NUM_CH*DUTY_W-1:0] active_o
);
  localparam int unsigned BankW = NUM_CH * DUTY_W;
  localparam logic [IDX_W-1:0] LastCh = IDX_W'(NUM_CH - 1);

  logic [BankW-1:0] shadow_q, shadow_d, active_q;

  // index decode only matches real channels, so out-of-range writes fall through
  always_comb begin
    shadow_d = shadow_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_en_i && wr_ch_i == IDX_W'(c)) shadow_d[c*DUTY_W +: DUTY_W] = wr_duty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (load_i) active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  a_r4_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_q));
  a_r3_bad_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_ch_i > LastCh) |=> $stable(shadow_q));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned DUTY_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     wrap_i,
  input  logic [DUTY_W-1:0]        phase_i,
  input  logic [NUM_CH*DUTY_W-1:0] shadow_i,
  input  logic [NUM_CH*DUTY_W-1:0] active_i,
  output logic [NUM_CH-1:0]        pwm_o
);
  logic [NUM_CH-1:0] staged_q, staged_d, pwm_q;
  logic [DUTY_W-1:0] phase_nxt;

  assign phase_nxt = phase_i + DUTY_W'(1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DUTY_W-1:0] cmp, cmp_new;
    assign cmp     = active_i[g*DUTY_W +: DUTY_W];
    assign cmp_new = shadow_i[g*DUTY_W +: DUTY_W];
    // at wrap, arm with the duty being loaded; otherwise drop on compare match
    assign staged_d[g] = wrap_i ? (cmp_new != '0) : (staged_q[g] && (phase_nxt != cmp));

    a_r5_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp == '0) |-> !staged_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      pwm_q    <= '0;
    end else if (tick_i) begin
      pwm_q    <= staged_q;
      staged_q <= staged_d;
    end
  end

  assign pwm_o = pwm_q;

  a_r7_edge_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pwm_q));
  a_r6_never_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&phase_i) |-> (staged_q == '0));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int unsigned NUM_CH  = DefNumCh,
  parameter int unsigned DUTY_W  = DefDutyW,
  parameter int unsigned IDX_W   = DefIdxW,
  parameter int unsigned PRESC_W = DefPrescW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_ch_i,
  input  logic [DUTY_W-1:0] wr_duty_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              wrap_o
);
  localparam int unsigned BankW = NUM_CH * DUTY_W;

  logic              tick, wrap;
  logic [DUTY_W-1:0] phase;
  logic [BankW-1:0]  shadow, active;

  pwm_timebase #(.PRESC_W(PRESC_W), .PHASE_W(DUTY_W)) u_timebase (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_o(tick), .wrap_o(wrap), .phase_o(phase)
  );

  pwm_duty_bank #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_duty_i(wr_duty_i),
    .load_i(wrap), .shadow_o(shadow), .active_o(active)
  );

  pwm_out_stage #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick), .wrap_i(wrap), .phase_i(phase),
    .shadow_i(shadow), .active_i(active), .pwm_o(pwm_o)
  );

  assign wrap_o = wrap;

  a_r9_wrap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
  a_r9_wrap_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> tick);
endmodule

// File: tb/pwm_multi_bench.sv
`timescale 1ns/1ps
module pwm_multi_bench;
  localparam int NUM_CH  = 10;
  localparam int DUTY_W  = 8;
  localparam int IDX_W   = 4;
  localparam int PRESC_W = 2;
  localparam int TICK    = 1 << PRESC_W;
  localparam int PERIOD  = TICK << DUTY_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_ch = '0;
  logic [DUTY_W-1:0] wr_duty = '0;
  logic [NUM_CH-1:0] pwm;
  logic              wrap;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int hi_cnt[NUM_CH];
  int duty_set[NUM_CH] = '{1, 17, 64, 128, 200, 254, 255, 2, 99, 173};

  pwm_multi #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .IDX_W(IDX_W), .PRESC_W(PRESC_W)) u_pwm_multi (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_duty_i(wr_duty), .pwm_o(pwm), .wrap_o(wrap)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_negs(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wrap();
    @(negedge clk);
    while (wrap !== 1'b1) @(negedge clk);
  endtask

  task automatic write_ch(int ch, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = IDX_W'(ch); wr_duty = DUTY_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called right after wait_wrap: covers one full period of output
  task automatic measure();
    for (int c = 0; c < NUM_CH; c++) hi_cnt[c] = 0;
    repeat (PERIOD) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) if (pwm[c]) hi_cnt[c]++;
    end
  endtask

  task automatic t_reset();
    wait_negs(3);
    check("R8", "pwm in reset", int'(pwm), 0);
    check("R8", "wrap in reset", int'(wrap), 0);
    rst_n = 1'b1;
    wait_negs(2);
    check("R8", "pwm after release", int'(pwm), 0);
    wait_wrap();
    measure();
    for (int c = 0; c < NUM_CH; c++) check("R8", $sformatf("ch%0d high clocks, no writes", c), hi_cnt[c], 0);
  endtask

  task automatic t_period();
    int n;
    wait_wrap();
    @(negedge clk);
    check("R9", "wrap width", int'(wrap), 0);
    n = 1;
    while (wrap !== 1'b1) begin @(negedge clk); n++; end
    check("R2", "clocks between wraps", n, PERIOD);
  endtask

  task automatic t_all_duties();
    for (int c = 0; c < NUM_CH; c++) write_ch(c, duty_set[c]);
    wait_wrap();
    measure();
    for (int c = 0; c < NUM_CH; c++)
      check("R6", $sformatf("R1 ch%0d high clocks", c), hi_cnt[c], duty_set[c] * TICK);
  endtask

  task automatic t_ignore_index();
    for (int i = NUM_CH; i < 16; i++) write_ch(i, 0);
    wait_wrap();
    measure();
    for (int c = 0; c < NUM_CH; c++)
      check("R3", $sformatf("ch%0d after bad-index writes", c), hi_cnt[c], duty_set[c] * TICK);
  endtask

  task automatic t_extremes();
    write_ch(0, 0);
    write_ch(1, 255);
    wait_wrap();
    measure();
    check("R5", "ch0 duty 0 high clocks", hi_cnt[0], 0);
    check("R6", "ch1 duty 255 high clocks", hi_cnt[1], 255 * TICK);
  endtask

  task automatic t_latency();
    write_ch(1, 3);
    wait_wrap();
    wait_wrap();
    wait_negs(4);
    check("R7", "ch1 before first tick", int'(pwm[1]), 0);
    wait_negs(1);
    check("R7", "ch1 one tick after wrap", int'(pwm[1]), 1);
    wait_negs(11);
    check("R7", "ch1 last high clock", int'(pwm[1]), 1);
    wait_negs(1);
    check("R7", "ch1 after 3 ticks", int'(pwm[1]), 0);
  endtask

  task automatic t_shadow();
    write_ch(0, 100);
    wait_wrap();
    wait_wrap();
    wait_negs(60);
    write_ch(0, 30);
    wait_negs(183);
    check("R4", "ch0 at phase 60 after mid-period write", int'(pwm[0]), 1);
    wait_wrap();
    measure();
    check("R4", "ch0 high clocks next period", hi_cnt[0], 30 * TICK);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_negs(2);
    check("R8", "pwm during mid-run reset", int'(pwm), 0);
    rst_n = 1'b1;
    wait_wrap();
    measure();
    for (int c = 0; c < NUM_CH; c++) check("R8", $sformatf("ch%0d after mid-run reset", c), hi_cnt[c], 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    summary();
  end

  initial begin
    t_reset();
    t_period();
    t_all_duties();
    t_ignore_index();
    t_extremes();
    t_latency();
    t_shadow();
    t_mid_reset();
    summary();
  end
endmodule